// File: doc/BRIEF.md
# Phase-Shifted Combined-Edge PWM Generator

This block is a free-running PWM timer that serves several output pairs. One shared counter runs either upward with wrap-around or up-down in a triangle. Each pair holds two compare values. In combined mode the pair's output rises when the counter reaches the lower value and falls when it reaches the upper one. Giving each pair a different lower value shifts its pulse in time while all pairs keep the same period. This yields phase-shifted waveforms for multi-phase power stages.

Software-side requests reach the block as normalized 16-bit edge positions. The built-in converter scales them by the current period, then checks them, and writes them into a per-pair buffer. From there they take effect at once or at the next loading point. A sync strobe pushes all buffered values through immediately. Each pair drives a high-side and a low-side output, and a programmable dead time separates them.

Top module: `pshift_pwm`

## Requirements
- R1: While reset is held, the counter output reads 0, every high-side and low-side output is 0, and the error flag is 0.
- R2: With up-down mode off, the counter counts 0,1,...,P and wraps from P (the period input) to 0. With up-down mode on, it counts 0 up to P and then down to 1, so one cycle lasts 2P clocks.
- R3: A combined pair's raw output is high in the cycle after the counter holds a value c with first <= c < second. The effective duty therefore equals second minus first counts, and the pair's phase is set by first.
- R4: If a combined pair has first >= second, its high-side output stays low for the whole period.
- R5: An edge request r (0..0x8000, where 0x8000 means full scale) converts to ticks = (P*r) >> 15. When the first-edge request equals 0x8000, one is added to its ticks. A non-combined pair is high in the cycle after any count c < first. So a request of 0 gives constant low, 0x4000 gives half the counts, and 0x8000 gives constant high.
- R6: A request with either edge above 0x8000 is dropped: no compare value changes, and the error flag is high for exactly the one cycle after the request.
- R7: For a non-combined pair in up-down mode, the stored first compare is half of its converted ticks, rounded down.
- R8: A request with the immediate flag set changes the pair's output from the second clock edge after the request is sampled.
- R9: A request without the immediate flag only fills the pair's buffer. It reaches the output after the next loading point, which is the clock where the counter's next value is 0.
- R10: A sync strobe moves every pair's buffered compare values into use at that clock edge.
- R11: The dead time d (0..63 clocks, one field per pair) delays each rising edge of the pair's high-side and low-side outputs by d cycles. The two outputs are never high together.
- R12: If the dead time is at least as long as a pulse, that output stays low for the whole pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_i | input | CW | Counter modulo P |
| updown_i | input | 1 | 1 selects up-down counting |
| sync_i | input | 1 | Strobe: transfer all buffered compare values now |
| comb_i | input | NPAIR | Per pair: 1 = combined two-edge mode |
| dtime_i | input | NPAIR*DTW | Per pair dead time in clocks; pair k uses bits k*DTW upward |
| req_v_i | input | 1 | Edge request valid |
| req_pair_i | input | SELW | Target pair index |
| req_first_i | input | 16 | Normalized first-edge request |
| req_second_i | input | 16 | Normalized second-edge request |
| req_now_i | input | 1 | 1 = apply at once, 0 = wait for loading point |
| err_o | output | 1 | Out-of-range request flag, one cycle |
| cnt_o | output | CW | Counter value |
| pwm_hi_o | output | NPAIR | High-side outputs |
| pwm_lo_o | output | NPAIR | Low-side outputs |

## Verification
The bench builds the block with three pairs, a 16-bit counter, 6-bit dead-time fields and dead-time insertion enabled, and runs it with a period of 100. Three pairs allow a distinct phase on each output in a single measured window. They also let one window mix combined and non-combined pairs. A period of 100 makes the converted tick values easy to derive by hand, including the truncated ones such as 12 and 53. The 6-bit dead-time field admits delays longer than a short pulse, which reaches the swallowed-pulse case.

// File: rtl/pshift_pkg.sv
package pshift_pkg;
   localparam int unsigned NRM_W     = 16;
   localparam int unsigned NRM_SHIFT = 15;
   localparam logic [NRM_W-1:0] NRM_FULL = 16'h8000;

   typedef enum logic {
      CNT_UP   = 1'b0,
      CNT_DOWN = 1'b1
   } cnt_dir_e;
endpackage

// File: rtl/pshift_cnt.sv
module pshift_cnt
   import pshift_pkg::*;
#(
   parameter int unsigned CW = 16
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] period_i,
   input  logic          updown_i,
   output logic [CW-1:0] cnt_o,
   output logic          load_o
);
   cnt_dir_e      dir_q;
   logic [CW-1:0] cnt_q;
   logic          top_hit;
   logic          turn_ok;
   logic          bot_hit;

   always_comb begin
      top_hit = (dir_q == CNT_UP) && (cnt_q >= period_i);
      turn_ok = updown_i && (period_i > CW'(1));
      bot_hit = (dir_q == CNT_DOWN) && (cnt_q <= CW'(1));
      // next count returns to zero
      load_o  = (top_hit && !turn_ok) || bot_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         dir_q <= CNT_UP;
      end else if (top_hit) begin
         if (turn_ok) begin
            cnt_q <= period_i - CW'(1);
            dir_q <= CNT_DOWN;
         end else begin
            cnt_q <= '0;
         end
      end else if (bot_hit) begin
         cnt_q <= '0;
         dir_q <= CNT_UP;
      end else if (dir_q == CNT_UP) begin
         cnt_q <= cnt_q + CW'(1);
      end else begin
         cnt_q <= cnt_q - CW'(1);
      end
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/pshift_tick_conv.sv
module pshift_tick_conv
   import pshift_pkg::*;
#(
   parameter int unsigned CW = 16,
   localparam int unsigned TW = CW + 1
)(
   input  logic [CW-1:0]    period_i,
   input  logic             updown_i,
   input  logic             combine_i,
   input  logic [NRM_W-1:0] first_i,
   input  logic [NRM_W-1:0] second_i,
   output logic [TW-1:0]    first_t_o,
   output logic [TW-1:0]    second_t_o,
   output logic             bad_o
);
   localparam int unsigned PW = CW + NRM_W;

   logic [PW-1:0] prod_a;
   logic [PW-1:0] prod_b;
   logic [TW-1:0] tick_a;
   logic [TW-1:0] tick_b;
   logic [TW-1:0] tick_a_adj;

   always_comb begin
      prod_a = PW'(period_i) * PW'(first_i);
      prod_b = PW'(period_i) * PW'(second_i);
      tick_a = prod_a[NRM_SHIFT +: TW];
      tick_b = prod_b[NRM_SHIFT +: TW];
      // full-scale first edge lands one past the period: constant high
      tick_a_adj = (first_i == NRM_FULL) ? tick_a + TW'(1) : tick_a;
      // single-compare triangle mode halves the compare value
      first_t_o  = (!combine_i && updown_i) ? (tick_a_adj >> 1) : tick_a_adj;
      second_t_o = tick_b;
      bad_o      = (first_i > NRM_FULL) || (second_i > NRM_FULL);
   end
endmodule

// File: rtl/pshift_chan.sv
module pshift_chan #(
   parameter int unsigned CW    = 16,
   parameter int unsigned DTW   = 6,
   parameter bit          DT_EN = 1'b1,
   localparam int unsigned TW = CW + 1
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic [CW-1:0]  cnt_i,
   input  logic           combine_i,
   input  logic           load_i,
   input  logic           wr_i,
   input  logic           now_i,
   input  logic [TW-1:0]  first_t_i,
   input  logic [TW-1:0]  second_t_i,
   input  logic [DTW-1:0] dtime_i,
   output logic           hi_o,
   output logic           lo_o
);
   logic [TW-1:0] buf_a_q;
   logic [TW-1:0] buf_b_q;
   logic [TW-1:0] act_a_q;
   logic [TW-1:0] act_b_q;
   logic [TW-1:0] cnt_ext;
   logic          raw_d;
   logic          raw_q;
   logic          armed_q;

   // shadow and active compare pair
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_a_q <= '0;
         buf_b_q <= '0;
         act_a_q <= '0;
         act_b_q <= '0;
      end else begin
         if (wr_i) begin
            buf_a_q <= first_t_i;
            buf_b_q <= second_t_i;
         end
         if (wr_i && now_i) begin
            act_a_q <= first_t_i;
            act_b_q <= second_t_i;
         end else if (load_i) begin
            act_a_q <= buf_a_q;
            act_b_q <= buf_b_q;
         end
      end
   end

   always_comb begin
      cnt_ext = TW'(cnt_i);
      if (combine_i) raw_d = (cnt_ext >= act_a_q) && (cnt_ext < act_b_q);
      else           raw_d = (cnt_ext < act_a_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q   <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         raw_q   <= raw_d;
         armed_q <= 1'b1;
      end
   end

   generate
      if (DT_EN) begin : g_dt
         localparam logic [DTW-1:0] RUN_MAX = '1;
         logic [DTW-1:0] run_hi_q;
         logic [DTW-1:0] run_lo_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_hi_q <= '0;
               run_lo_q <= '0;
            end else begin
               if (raw_d && raw_q)
                  run_hi_q <= (run_hi_q == RUN_MAX) ? run_hi_q : run_hi_q + DTW'(1);
               else
                  run_hi_q <= '0;
               if (!raw_d && !raw_q)
                  run_lo_q <= (run_lo_q == RUN_MAX) ? run_lo_q : run_lo_q + DTW'(1);
               else
                  run_lo_q <= '0;
            end
         end

         assign hi_o = raw_q && (run_hi_q >= dtime_i);
         assign lo_o = armed_q && !raw_q && (run_lo_q >= dtime_i);
      end else begin : g_nodt
         logic unused_dt;
         assign unused_dt = ^dtime_i;
         assign hi_o = raw_q;
         assign lo_o = armed_q && !raw_q;
      end
   endgenerate
endmodule

// File: rtl/pshift_pwm.sv
module pshift_pwm
   import pshift_pkg::*;
#(
   parameter int unsigned NPAIR = 3,
   parameter int unsigned CW    = 16,
   parameter int unsigned DTW   = 6,
   parameter bit          DT_EN = 1'b1,
   localparam int unsigned SELW = (NPAIR > 1) ? $clog2(NPAIR) : 1,
   localparam int unsigned TW   = CW + 1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CW-1:0]      period_i,
   input  logic               updown_i,
   input  logic               sync_i,
   input  logic [NPAIR-1:0]   comb_i,
   input  logic [NPAIR*DTW-1:0] dtime_i,
   input  logic               req_v_i,
   input  logic [SELW-1:0]    req_pair_i,
   input  logic [NRM_W-1:0]   req_first_i,
   input  logic [NRM_W-1:0]   req_second_i,
   input  logic               req_now_i,
   output logic               err_o,
   output logic [CW-1:0]      cnt_o,
   output logic [NPAIR-1:0]   pwm_hi_o,
   output logic [NPAIR-1:0]   pwm_lo_o
);
   generate
      if (NPAIR < 1 || NPAIR > 16) begin : g_bad_npair
         $error("pshift_pwm: NPAIR must lie in 1..16");
      end
      if (CW < 2 || CW > 24) begin : g_bad_cw
         $error("pshift_pwm: CW must lie in 2..24");
      end
      if (DTW < 1 || DTW > 16) begin : g_bad_dtw
         $error("pshift_pwm: DTW must lie in 1..16");
      end
   endgenerate

   logic          ld_pt;
   logic          load_all;
   logic          pair_ok;
   logic          comb_sel;
   logic          req_bad;
   logic          err_q;
   logic [TW-1:0] first_t;
   logic [TW-1:0] second_t;

   pshift_cnt #(.CW(CW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .period_i (period_i),
      .updown_i (updown_i),
      .cnt_o    (cnt_o),
      .load_o   (ld_pt)
   );

   always_comb begin
      pair_ok  = 32'(req_pair_i) < NPAIR;
      comb_sel = pair_ok ? comb_i[req_pair_i] : 1'b0;
      load_all = ld_pt || sync_i;
   end

   pshift_tick_conv #(.CW(CW)) u_conv (
      .period_i   (period_i),
      .updown_i   (updown_i),
      .combine_i  (comb_sel),
      .first_i    (req_first_i),
      .second_i   (req_second_i),
      .first_t_o  (first_t),
      .second_t_o (second_t),
      .bad_o      (req_bad)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= req_v_i && req_bad;
   end
   assign err_o = err_q;

   generate
      for (genvar k = 0; k < NPAIR; k++) begin : g_pair
         logic wr_k;
         assign wr_k = req_v_i && !req_bad && pair_ok && (req_pair_i == SELW'(k));

         pshift_chan #(.CW(CW), .DTW(DTW), .DT_EN(DT_EN)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .cnt_i      (cnt_o),
            .combine_i  (comb_i[k]),
            .load_i     (load_all),
            .wr_i       (wr_k),
            .now_i      (req_now_i),
            .first_t_i  (first_t),
            .second_t_i (second_t),
            .dtime_i    (dtime_i[k*DTW +: DTW]),
            .hi_o       (pwm_hi_o[k]),
            .lo_o       (pwm_lo_o[k])
         );
      end
   endgenerate
endmodule

// File: rtl/pshift_pwm_chk.sv
module pshift_pwm_chk
   import pshift_pkg::*;
#(
   parameter int unsigned NPAIR = 3,
   parameter int unsigned CW    = 16
)(
   input logic             clk,
   input logic             rst_n,
   input logic [CW-1:0]    period_i,
   input logic             updown_i,
   input logic             req_v_i,
   input logic [NRM_W-1:0] req_first_i,
   input logic [NRM_W-1:0] req_second_i,
   input logic             err_o,
   input logic [CW-1:0]    cnt_o,
   input logic [NPAIR-1:0] pwm_hi_o,
   input logic [NPAIR-1:0] pwm_lo_o
);
   // R2: counter never passes the modulo
   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_o <= period_i);

   // R2: up counting wraps to zero after the modulo
   p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!updown_i && cnt_o == period_i) |=> (cnt_o == '0));

   // R6: an out-of-range request raises the flag next cycle
   p_err_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_v_i && ((req_first_i > NRM_FULL) || (req_second_i > NRM_FULL))) |=> err_o);

   // R6: without a request the flag is low next cycle
   p_err_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !req_v_i |=> !err_o);

   // R11: complementary outputs never overlap
   p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_hi_o & pwm_lo_o) == '0);
endmodule

bind pshift_pwm pshift_pwm_chk #(.NPAIR(NPAIR), .CW(CW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .period_i     (period_i),
   .updown_i     (updown_i),
   .req_v_i      (req_v_i),
   .req_first_i  (req_first_i),
   .req_second_i (req_second_i),
   .err_o        (err_o),
   .cnt_o        (cnt_o),
   .pwm_hi_o     (pwm_hi_o),
   .pwm_lo_o     (pwm_lo_o)
);

// File: tb/tb_pshift_pwm.sv
module tb_pshift_pwm;
   localparam int NP  = 3;
   localparam int CW  = 16;
   localparam int DTW = 6;
   localparam int P   = 100;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [CW-1:0]     period = CW'(P);
   logic              updown = 1'b0;
   logic              sync = 1'b0;
   logic [NP-1:0]     comb = '1;
   logic [NP*DTW-1:0] dtime = '0;
   logic              req_v = 1'b0;
   logic [1:0]        req_pair = '0;
   logic [15:0]       req_first = '0;
   logic [15:0]       req_second = '0;
   logic              req_now = 1'b0;
   logic              err;
   logic [CW-1:0]     cnt;
   logic [NP-1:0]     hi;
   logic [NP-1:0]     lo;

   always #2.5 clk = ~clk;

   pshift_pwm #(.NPAIR(NP), .CW(CW), .DTW(DTW), .DT_EN(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .period_i(period), .updown_i(updown),
      .sync_i(sync), .comb_i(comb), .dtime_i(dtime), .req_v_i(req_v),
      .req_pair_i(req_pair), .req_first_i(req_first), .req_second_i(req_second),
      .req_now_i(req_now), .err_o(err), .cnt_o(cnt), .pwm_hi_o(hi), .pwm_lo_o(lo)
   );

   int n_run = 0;
   int n_fail = 0;

   typedef struct {
      int    pair;
      int    highs;
      int    lows;
      int    rise;   // -2 skips the rise check
      string tag;
   } exp_t;
   exp_t sbq[$];

   function automatic int ticks(int r);
      return (P * r) >>> 15;
   endfunction

   task automatic check(string tag, string what, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic push_exp(int pair, int highs, int lows, int rise, string tag);
      exp_t e;
      e.pair = pair; e.highs = highs; e.lows = lows; e.rise = rise; e.tag = tag;
      sbq.push_back(e);
   endtask

   task automatic drive_req(int pair, int f, int s, bit now);
      @(negedge clk);
      req_v = 1'b1; req_pair = 2'(pair); req_first = 16'(f);
      req_second = 16'(s); req_now = now;
      @(negedge clk);
      req_v = 1'b0;
   endtask

   task automatic wait_zero();
      @(negedge clk);
      while (cnt != '0) @(negedge clk);
   endtask

   // monitor: measure one window of n samples, then pop and compare
   task automatic measure_pop(int n);
      int hc[NP];
      int lc[NP];
      int rs[NP];
      bit pv[NP];
      exp_t e;
      wait_zero();
      wait_zero();
      for (int p = 0; p < NP; p++) begin hc[p] = 0; lc[p] = 0; rs[p] = -1; pv[p] = 1'b0; end
      for (int k = 0; k < n; k++) begin
         if (k > 0) @(negedge clk);
         for (int p = 0; p < NP; p++) begin
            if (hi[p]) hc[p]++;
            if (lo[p]) lc[p]++;
            if (k > 0 && hi[p] && !pv[p] && rs[p] < 0) rs[p] = k - 1;
            pv[p] = hi[p];
         end
      end
      while (sbq.size() > 0) begin
         e = sbq.pop_front();
         check(e.tag, $sformatf("pair%0d high count", e.pair), hc[e.pair], e.highs);
         check(e.tag, $sformatf("pair%0d low count", e.pair), lc[e.pair], e.lows);
         if (e.rise != -2)
            check(e.tag, $sformatf("pair%0d rise count", e.pair), rs[e.pair], e.rise);
      end
   endtask

   task automatic do_reset(bit ud);
      @(negedge clk);
      rst_n = 1'b0;
      updown = ud;
      repeat (3) @(negedge clk);
      check("R1", "cnt in reset", int'(cnt), 0);
      check("R1", "hi in reset", int'(hi), 0);
      check("R1", "lo in reset", int'(lo), 0);
      check("R1", "err in reset", int'(err), 0);
      rst_n = 1'b1;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : main
      int bad;
      int mx;
      int prev;
      int ones;
      int len;

      do_reset(1'b0);

      // R2: up counting
      bad = 0; mx = 0; prev = -1;
      for (int k = 0; k < 2 * P + 4; k++) begin
         @(negedge clk);
         if (int'(cnt) > mx) mx = int'(cnt);
         if (prev == P && cnt != '0) bad++;
         if (prev >= 0 && cnt == '0 && prev != P) bad++;
         prev = int'(cnt);
      end
      check("R2", "up max", mx, P);
      check("R2", "up wrap errors", bad, 0);

      // R3: three pairs, same width, staggered first edges
      drive_req(0, 16'h0000, 16'h2000, 1'b1);
      drive_req(1, 16'h1000, 16'h3000, 1'b1);
      drive_req(2, 16'h2000, 16'h4000, 1'b1);
      push_exp(0, ticks('h2000) - ticks('h0000), P + 1 - 25, ticks('h0000), "R3");
      push_exp(1, ticks('h3000) - ticks('h1000), P + 1 - 25, ticks('h1000), "R3");
      push_exp(2, ticks('h4000) - ticks('h2000), P + 1 - 25, ticks('h2000), "R3");
      measure_pop(P + 1);

      // R4: inverted edge order on pair1 (62 >= 37)
      drive_req(1, 16'h5000, 16'h3000, 1'b1);
      push_exp(1, 0, P + 1, -1, "R4");
      push_exp(0, 25, P + 1 - 25, 0, "R4");
      measure_pop(P + 1);

      // R6: out-of-range request on pair2
      @(negedge clk);
      req_v = 1'b1; req_pair = 2'd2; req_first = 16'h8001; req_second = 16'h0100; req_now = 1'b1;
      @(negedge clk);
      req_v = 1'b0;
      check("R6", "err after bad request", int'(err), 1);
      @(negedge clk);
      check("R6", "err one cycle only", int'(err), 0);
      push_exp(2, 25, P + 1 - 25, 25, "R6");
      measure_pop(P + 1);

      // R5: conversion, single-compare pairs and full-scale combined
      comb = 3'b100;
      drive_req(0, 16'h4000, 16'h0000, 1'b1);
      drive_req(1, 16'h8000, 16'h0000, 1'b1);
      drive_req(2, 16'h0000, 16'h8000, 1'b1);
      push_exp(0, ticks('h4000), P + 1 - ticks('h4000), 0, "R5");
      push_exp(1, P + 1, 0, -1, "R5");
      push_exp(2, ticks('h8000), P + 1 - ticks('h8000), 0, "R5");
      measure_pop(P + 1);
      drive_req(2, 16'h0000, 16'h0000, 1'b1);
      push_exp(2, 0, P + 1, -1, "R5");
      comb = 3'b000;
      measure_pop(P + 1);

      // R9: deferred update keeps old compare until loading point
      comb = 3'b111;
      drive_req(0, 16'h0000, 16'h4000, 1'b1);
      wait_zero();
      while (cnt != CW'(2)) @(negedge clk);
      req_v = 1'b1; req_pair = 2'd0; req_first = 16'h4000; req_second = 16'h8000; req_now = 1'b0;
      @(negedge clk);
      req_v = 1'b0;
      bad = 0;
      while (cnt != '0) begin
         if (cnt >= CW'(5) && cnt <= CW'(49) && !hi[0]) bad++;
         @(negedge clk);
      end
      check("R9", "old waveform before load point", bad, 0);
      push_exp(0, 50, P + 1 - 50, 50, "R9");
      measure_pop(P + 1);

      // R8: immediate update inside the period
      wait_zero();
      while (cnt != CW'(2)) @(negedge clk);
      req_v = 1'b1; req_pair = 2'd0; req_first = 16'h0000; req_second = 16'h4000; req_now = 1'b1;
      @(negedge clk);
      req_v = 1'b0;
      ones = 0;
      while (cnt != '0) begin
         if (cnt >= CW'(5) && cnt <= CW'(49) && hi[0]) ones++;
         @(negedge clk);
      end
      check("R8", "new waveform within period", ones, 45);

      // R10: sync strobe transfers buffered values mid-period
      wait_zero();
      while (cnt != CW'(2)) @(negedge clk);
      req_v = 1'b1; req_pair = 2'd0; req_first = 16'h2000; req_second = 16'h6000; req_now = 1'b0;
      @(negedge clk);
      req_pair = 2'd1;
      @(negedge clk);
      req_v = 1'b0;
      while (cnt != CW'(10)) @(negedge clk);
      sync = 1'b1;
      @(negedge clk);
      sync = 1'b0;
      ones = 0;
      while (cnt != '0) begin
         if (cnt >= CW'(30) && cnt <= CW'(70)) ones += int'(hi[0]) + int'(hi[1]);
         @(negedge clk);
      end
      check("R10", "outputs after sync", ones, 82);

      // R11: dead time 5 on pair0, pair1 with none
      dtime = {6'd0, 6'd0, 6'd5};
      push_exp(0, 50 - 5, 51 - 5, 25 + 5, "R11");
      push_exp(1, 50, 51, 25, "R11");
      measure_pop(P + 1);

      // R12: dead time 10 swallows a 3-count pulse on pair1
      dtime = {6'd0, 6'd10, 6'd5};
      drive_req(1, 16'h4000, 16'h4400, 1'b1);
      push_exp(1, 0, P + 1 - (ticks('h4400) - ticks('h4000)) - 10, -1, "R12");
      measure_pop(P + 1);

      // R2 / R7: up-down counting and halved single compare
      dtime = '0;
      comb = 3'b000;
      do_reset(1'b1);
      wait_zero();
      mx = 0; len = 0;
      @(negedge clk);
      len = 1;
      while (cnt != '0) begin
         if (int'(cnt) > mx) mx = int'(cnt);
         len++;
         @(negedge clk);
      end
      check("R2", "up-down max", mx, P);
      check("R2", "up-down cycle length", len, 2 * P);
      drive_req(0, 16'h4000, 16'h0000, 1'b1);
      drive_req(1, 16'h8000, 16'h0000, 1'b1);
      push_exp(0, 2 * (ticks('h4000) / 2) - 1, 2 * P - (2 * (ticks('h4000) / 2) - 1), -2, "R7");
      push_exp(1, 2 * ((P + 1) / 2) - 1, 2 * P - (2 * ((P + 1) / 2) - 1), -2, "R7");
      push_exp(2, 0, 2 * P, -1, "R7");
      measure_pop(2 * P);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule